// File: doc/BRIEF.md
# LIN Header Break and Sync Detector

This block sits behind a receive-line synchronizer on a single-wire LIN-style bus and finds the start of each frame header. It times how long the line stays dominant (low), using an oversampling tick supplied from outside. It then checks the recessive delimiter that follows and receives the next character as an ordinary 8N1 UART byte that must equal the sync pattern. The tick period sets the bit time, so a single build works at any rate up to 20 kbit/s, and 9600 bit/s is the usual setting.

Three one-cycle pulses go to the downstream frame handler. `hdr_start_o` marks an accepted break. `sync_ok_o` and `sync_err_o` give the result of the delimiter and sync check. `frm_err_o` flags a dominant period that is too long for a character but too short for a break. Dominant runs shorter than a character are ordinary traffic or noise and cause no pulse. A valid break restarts header detection in any state.

Top module: `lin_hdr_det`

## Requirements
- R1: When the line returns high after a low run of at least BRK_BITS (13) bit times, `hdr_start_o` pulses for exactly one clock.
- R2: A low run of at least CHAR_BITS (10) bit times but under BRK_BITS bit times pulses `frm_err_o` once and never `hdr_start_o`.
- R3: Outside a header check, a low run shorter than CHAR_BITS bit times (data characters, glitches) raises no output pulse.
- R4: If the line falls within one bit time after an accepted break, `sync_err_o` pulses and the detector returns to idle.
- R5: After a delimiter of one bit time or more, the next falling edge starts an 8N1 character: start bit, 8 data bits LSB first, then a stop bit. Each bit is sampled at mid-bit, counted from the falling edge. A value of 0x55 with a high stop bit pulses `sync_ok_o` once.
- R6: A sync character other than 0x55 pulses `sync_err_o`. The detector then goes idle, and later characters without a new break cause no `sync_ok_o`.
- R7: A stop bit sampled low in the sync character pulses `sync_err_o`, even when the data bits are 0x55.
- R8: A start bit that is high again at its mid-bit sample is treated as noise. The detector keeps waiting for the sync start bit.
- R9: A valid break restarts header detection in any state, including in the middle of a sync character.
- R10: One bit time equals OVS pulses of `os_tick_i`, whatever the tick spacing in clocks.
- R11: While reset is asserted, and in the first cycle after it, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_i | input | 1 | Synchronized receive line, low = dominant |
| os_tick_i | input | 1 | Oversampling tick, OVS per bit time |
| hdr_start_o | output | 1 | One-cycle pulse on break acceptance |
| sync_ok_o | output | 1 | One-cycle pulse: delimiter and sync byte valid |
| sync_err_o | output | 1 | One-cycle pulse: short delimiter, wrong byte or low stop bit |
| frm_err_o | output | 1 | One-cycle pulse: over-long dominant run that is no break |

## Verification
A wrong dominant-run count shows up at the end of the low period. A break is then missed or turned into a frame error, or a frame error appears in place of a break, in the cycle after the line rises. A wrong bit phase or bit index in the sync receiver shows at the stop-bit sample, about ten bit times after the start edge, as a `sync_err_o` where `sync_ok_o` was due, or the reverse. A stuck state shows as a missing result pulse, or as a result pulse with no break before it. The bench therefore counts all four pulses over each scenario window and compares the counts with the expected ones.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;
    typedef enum logic [1:0] {
        SY_IDLE,
        SY_DELIM,
        SY_WAIT,
        SY_RECV
    } sync_st_e;
endpackage

// File: rtl/lin_low_timer.sv
module lin_low_timer #(
    parameter int OVS       = 16,
    parameter int BRK_BITS  = 13,
    parameter int CHAR_BITS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx,
    input  logic tick,
    output logic brk_o,
    output logic ferr_o
);
    localparam int BRK_TICKS  = OVS * BRK_BITS;
    localparam int CHAR_TICKS = OVS * CHAR_BITS;
    localparam int CW         = $clog2(BRK_TICKS + 1);
    localparam logic [CW-1:0] BRK_T  = CW'(BRK_TICKS);
    localparam logic [CW-1:0] CHAR_T = CW'(CHAR_TICKS);

    typedef struct packed {
        logic          rx;
        logic [CW-1:0] cnt;
        logic          brk;
        logic          ferr;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d      = tmr_q;
        tmr_d.rx   = rx;
        tmr_d.brk  = 1'b0;
        tmr_d.ferr = 1'b0;
        if (!rx) begin
            if (tick && tmr_q.cnt != BRK_T) begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end else begin
            tmr_d.cnt = '0;
            if (!tmr_q.rx) begin
                if (tmr_q.cnt >= BRK_T) begin
                    tmr_d.brk = 1'b1;
                end else if (tmr_q.cnt >= CHAR_T) begin
                    tmr_d.ferr = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '{rx: 1'b1, cnt: '0, brk: 1'b0, ferr: 1'b0};
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign brk_o  = tmr_q.brk;
    assign ferr_o = tmr_q.ferr;
endmodule

// File: rtl/lin_sync_rx.sv
module lin_sync_rx
    import lin_hdr_pkg::*;
#(
    parameter int         OVS      = 16,
    parameter logic [7:0] SYNC_VAL = 8'h55
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx,
    input  logic tick,
    input  logic brk,
    output logic ok_o,
    output logic err_o
);
    localparam int PW = $clog2(OVS);
    localparam logic [PW-1:0] LAST_PH = PW'(OVS - 1);
    localparam logic [PW-1:0] HALF_PH = PW'(OVS / 2);

    typedef struct packed {
        sync_st_e      st;
        logic [PW-1:0] ph;
        logic [3:0]    bitn;
        logic [7:0]    sh;
        logic          ok;
        logic          err;
    } srx_t;

    srx_t srx_d, srx_q;

    always_comb begin
        srx_d     = srx_q;
        srx_d.ok  = 1'b0;
        srx_d.err = 1'b0;
        if (brk) begin
            srx_d.st = SY_DELIM;
            srx_d.ph = '0;
        end else begin
            case (srx_q.st)
                SY_DELIM: begin
                    if (!rx) begin
                        srx_d.err = 1'b1;
                        srx_d.st  = SY_IDLE;
                    end else if (tick) begin
                        if (srx_q.ph == LAST_PH) srx_d.st = SY_WAIT;
                        else                     srx_d.ph = srx_q.ph + 1'b1;
                    end
                end
                SY_WAIT: begin
                    if (!rx) begin
                        srx_d.st   = SY_RECV;
                        srx_d.ph   = '0;
                        srx_d.bitn = '0;
                    end
                end
                SY_RECV: begin
                    if (tick) begin
                        if (srx_q.ph == HALF_PH) begin
                            if (srx_q.bitn == 4'd0) begin
                                if (rx) srx_d.st = SY_WAIT;
                            end else if (srx_q.bitn < 4'd9) begin
                                srx_d.sh = {rx, srx_q.sh[7:1]};
                            end else begin
                                srx_d.st = SY_IDLE;
                                if (rx && srx_q.sh == SYNC_VAL) srx_d.ok  = 1'b1;
                                else                            srx_d.err = 1'b1;
                            end
                        end
                        if (srx_q.ph == LAST_PH) begin
                            srx_d.ph   = '0;
                            srx_d.bitn = srx_q.bitn + 1'b1;
                        end else begin
                            srx_d.ph = srx_q.ph + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srx_q <= '{st: SY_IDLE, ph: '0, bitn: '0, sh: '0, ok: 1'b0, err: 1'b0};
        end else begin
            srx_q <= srx_d;
        end
    end

    assign ok_o  = srx_q.ok;
    assign err_o = srx_q.err;
endmodule

// File: rtl/lin_hdr_det.sv
module lin_hdr_det #(
    parameter int         OVS       = 16,
    parameter int         BRK_BITS  = 13,
    parameter int         CHAR_BITS = 10,
    parameter logic [7:0] SYNC_VAL  = 8'h55
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    input  logic os_tick_i,
    output logic hdr_start_o,
    output logic sync_ok_o,
    output logic sync_err_o,
    output logic frm_err_o
);
    logic brk;

    lin_low_timer #(
        .OVS(OVS), .BRK_BITS(BRK_BITS), .CHAR_BITS(CHAR_BITS)
    ) u_tmr (
        .clk(clk), .rst_n(rst_n), .rx(rx_i), .tick(os_tick_i),
        .brk_o(brk), .ferr_o(frm_err_o)
    );

    lin_sync_rx #(
        .OVS(OVS), .SYNC_VAL(SYNC_VAL)
    ) u_srx (
        .clk(clk), .rst_n(rst_n), .rx(rx_i), .tick(os_tick_i), .brk(brk),
        .ok_o(sync_ok_o), .err_o(sync_err_o)
    );

    assign hdr_start_o = brk;
endmodule

// File: rtl/lin_hdr_det_chk.sv
module lin_hdr_det_chk #(
    parameter int OVS      = 16,
    parameter int BRK_BITS = 13
) (
    input logic clk,
    input logic rst_n,
    input logic rx,
    input logic tick,
    input logic hdr,
    input logic ok,
    input logic err,
    input logic fe
);
    localparam logic [31:0] BRK_RUN = 32'(OVS * BRK_BITS);

    logic [31:0] run_q, cap_q;
    logic        rx_prev_q, armed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q     <= '0;
            cap_q     <= '0;
            rx_prev_q <= 1'b1;
            armed_q   <= 1'b0;
        end else begin
            rx_prev_q <= rx;
            if (rx) run_q <= '0;
            else if (tick && run_q < 32'h00FF_FFFF) run_q <= run_q + 1;
            if (!rx_prev_q && rx) cap_q <= run_q;
            if (hdr) armed_q <= 1'b1;
            else if (ok || err) armed_q <= 1'b0;
        end
    end

    // R1
    hdr_min_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr |-> cap_q >= BRK_RUN);
    // R1
    hdr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr |=> !hdr);
    // R2
    hdr_fe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hdr && fe));
    // R5
    ok_after_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> armed_q);
    // R6
    err_after_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> armed_q);
    // R7
    ok_stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> $past(rx));
    // R5
    ok_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ok, err}));
endmodule

bind lin_hdr_det lin_hdr_det_chk #(.OVS(OVS), .BRK_BITS(BRK_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx(rx_i), .tick(os_tick_i),
    .hdr(hdr_start_o), .ok(sync_ok_o), .err(sync_err_o), .fe(frm_err_o)
);

// File: tb/tb_lin_hdr_det.sv
module tb_lin_hdr_det;
    localparam int CLK_PERIOD = 10;
    localparam int OVS = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx = 1'b1;
    logic tick = 1'b0;
    logic hdr, ok, err, fe;
    int   tdiv = 3;
    int   tcnt = 0;
    int   n_hdr = 0, n_ok = 0, n_err = 0, n_fe = 0;
    int   checks = 0, errors = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lin_hdr_det #(.OVS(OVS)) dut (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .os_tick_i(tick),
        .hdr_start_o(hdr), .sync_ok_o(ok), .sync_err_o(err), .frm_err_o(fe)
    );

    always @(posedge clk) begin
        if (tcnt >= tdiv - 1) begin
            tcnt <= 0;
            tick <= 1'b1;
        end else begin
            tcnt <= tcnt + 1;
            tick <= 1'b0;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            n_hdr += int'(hdr);
            n_ok  += int'(ok);
            n_err += int'(err);
            n_fe  += int'(fe);
        end
    end

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic wait_tick();
        do @(negedge clk); while (!tick);
    endtask

    task automatic hold(bit v, int n);
        @(negedge clk);
        rx = v;
        for (int i = 0; i < n; i++) wait_tick();
    endtask

    task automatic send_byte(logic [7:0] b, bit stopv);
        hold(1'b0, OVS);
        for (int i = 0; i < 8; i++) hold(b[i], OVS);
        hold(stopv, OVS);
        hold(1'b1, 2 * OVS);
    endtask

    task automatic brk_delim(int low_ticks, int hi_ticks);
        hold(1'b0, low_ticks);
        hold(1'b1, hi_ticks);
    endtask

    int b_hdr, b_ok, b_err, b_fe;
    task automatic mark();
        b_hdr = n_hdr; b_ok = n_ok; b_err = n_err; b_fe = n_fe;
    endtask

    task automatic expect_d(string tag, int dh, int dok, int derr, int dfe);
        hold(1'b1, 4);
        chk({tag, " hdr_start"}, n_hdr - b_hdr, dh);
        chk({tag, " sync_ok"},   n_ok - b_ok,   dok);
        chk({tag, " sync_err"},  n_err - b_err, derr);
        chk({tag, " frm_err"},   n_fe - b_fe,   dfe);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk("R11 reset outs", int'({hdr, ok, err, fe}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 post-reset outs", int'({hdr, ok, err, fe}), 0);
        hold(1'b1, 2 * OVS);

        mark(); brk_delim(14 * OVS, 2 * OVS); send_byte(8'h55, 1'b1);
        expect_d("R1 R5 valid header", 1, 1, 0, 0);

        mark(); brk_delim(13 * OVS + 4, OVS + 4); send_byte(8'h55, 1'b1);
        expect_d("R1 near-minimum break", 1, 1, 0, 0);

        mark(); brk_delim(12 * OVS, 2 * OVS);
        expect_d("R2 12-bit low", 0, 0, 0, 1);

        mark(); send_byte(8'h00, 1'b1); send_byte(8'h55, 1'b1); hold(1'b0, 3); hold(1'b1, OVS);
        expect_d("R3 plain chars and glitch", 0, 0, 0, 0);

        mark(); brk_delim(14 * OVS, OVS / 2); send_byte(8'h55, 1'b1);
        expect_d("R4 short delimiter", 1, 0, 1, 0);

        mark(); brk_delim(15 * OVS, 2 * OVS); send_byte(8'hA5, 1'b1);
        expect_d("R6 wrong sync value", 1, 0, 1, 0);
        mark(); send_byte(8'h55, 1'b1);
        expect_d("R6 no ok without new break", 0, 0, 0, 0);

        mark(); brk_delim(14 * OVS, 2 * OVS); send_byte(8'h55, 1'b0);
        expect_d("R7 low stop bit", 1, 0, 1, 0);

        mark(); brk_delim(14 * OVS, 2 * OVS); hold(1'b0, 2); hold(1'b1, OVS);
        send_byte(8'h55, 1'b1);
        expect_d("R8 start glitch", 1, 1, 0, 0);

        mark(); brk_delim(14 * OVS, 2 * OVS);
        hold(1'b0, OVS); hold(1'b1, OVS); hold(1'b0, 14 * OVS); hold(1'b1, 2 * OVS);
        send_byte(8'h55, 1'b1);
        expect_d("R9 break inside sync byte", 2, 1, 1, 0);

        for (int d = 2; d <= 6; d += 4) begin
            tdiv = d;
            mark(); brk_delim(14 * OVS, 2 * OVS); send_byte(8'h55, 1'b1);
            expect_d("R10 tick spacing", 1, 1, 0, 0);
        end

        void'($urandom(32'd1234));
        for (int k = 0; k < 24; k++) begin
            logic [7:0] b;
            tdiv = 2 + int'($urandom % 3);
            b = ($urandom % 2 == 0) ? 8'h55 : 8'($urandom);
            mark();
            brk_delim(13 * OVS + 4 + int'($urandom % (6 * OVS)), OVS + 4 + int'($urandom % (2 * OVS)));
            send_byte(b, 1'b1);
            expect_d("R5 R6 random frame", 1, (b == 8'h55) ? 1 : 0, (b == 8'h55) ? 0 : 1, 0);
        end

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule